// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns bytes into a Manchester-coded serial line signal. Each byte accepted on a valid/ready handshake becomes one frame. Before the data bits, the block can send a preamble whose length is 0 to 15 bit periods and whose content is one of four pattern types. Preamble bits and data bits pass through the same coder. In that coder a selectable polarity decides which mid-bit transition direction stands for a zero and which stands for a one.

The line rate comes from an external half-bit strobe. Each pulse of `half_tick` ends the current half-bit phase, so one bit period takes two strobes. Configuration is held in a small register-style word. A write-protect input blocks updates to it, and a read-back port shows the stored fields. A frame copies the configuration when it starts, so a write during a frame does not change that frame. When no frame is running the line rests at its idle level, which is high by default.

Top module: `mtx_top`

## Requirements
- R1: After reset the line is at the idle level (high), `busy` is 0, `s_ready` is 1 and `cfg_rdata` reads 0. The line stays at the idle level whenever `busy` is 0.
- R2: A configuration write stores the preamble length from `cfg_wdata[3:0]`, the pattern from `cfg_wdata[9:8]` and the polarity from `cfg_wdata[12]`. `cfg_rdata` shows these fields at the same positions and reads 0 in every other bit.
- R3: A configuration write made while `wp_en` is 1 has no effect on the stored configuration or on later frames.
- R4: A preamble length L of 1 to 15 sends exactly L preamble bit periods before the data. L = 0 sends no preamble, so the frame is 8 bit periods long.
- R5: Pattern code 0 sends preamble bits of 1 and code 1 sends bits of 0. Code 2 sends 0,1,0,1,… and code 3 sends 1,0,1,0,…, starting with the first character in the first preamble bit period.
- R6: With polarity 0, a bit of 0 is sent as low then high, and a bit of 1 is sent as high then low. The line always changes level at mid-bit.
- R7: With polarity 1, every half-bit level is inverted, and this applies to preamble bits as well as data bits.
- R8: The data byte follows the last preamble bit with no gap and is sent least significant bit first.
- R9: A byte is accepted on a clock edge where `s_valid` and `s_ready` are both 1. From the next cycle, `busy` is 1 and the first half-bit is on the line. `busy` stays 1 until the strobe that ends the last data half-bit, and `s_ready` is 0 while `busy` is 1.
- R10: The configuration in use is the one stored when the frame is accepted. A write during the frame does not change that frame.
- R11: Each `half_tick` pulse during a frame advances exactly one half-bit. Between pulses the line does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe that ends the current half-bit phase |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W (16) | Configuration write word |
| wp_en | input | 1 | Write-protect enable; blocks configuration writes while 1 |
| cfg_rdata | output | CFG_W (16) | Stored configuration, read back |
| s_valid | input | 1 | Byte offered |
| s_data | input | DATA_W (8) | Byte to send |
| s_ready | output | 1 | Block can accept a byte |
| line_out | output | 1 | Manchester-coded line |
| busy | output | 1 | Frame in progress |

## Verification
Frames are sent with every combination of the four preamble patterns and the two polarities. Preamble lengths of 0, 1 and 15 and random lengths are used. This separates a swapped pattern code, an alternating pattern that starts on the wrong character, and a polarity that inverts only the data or only the preamble. Data bytes such as 0x01, 0x80, 0x00, 0xFF and random values show whether the bit order is wrong or whether bits are dropped or repeated at the preamble-to-data boundary. The gaps between strobes vary at random, which checks that the line moves only on a strobe. Writes made during a frame and writes made under write protect check that the configuration is frozen when and only when it should be.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   // register layout: fixed field positions of the configuration word
   localparam int PLEN_W   = 4;
   localparam int PLEN_LSB = 0;
   localparam int PAT_LSB  = 8;
   localparam int POL_BIT  = 12;
   localparam int CFG_MIN_W = POL_BIT + 1;

   typedef enum logic [1:0] {
      PAT_ONES  = 2'd0,
      PAT_ZEROS = 2'd1,
      PAT_LOHI  = 2'd2,
      PAT_HILO  = 2'd3
   } pat_e;

   typedef struct packed {
      logic              pol;
      pat_e              pat;
      logic [PLEN_W-1:0] plen;
   } mtx_cfg_t;

   // preamble bit for a given pattern and preamble bit parity
   function automatic logic pre_bit(input pat_e pat, input logic odd);
      case (pat)
         PAT_ONES:  pre_bit = 1'b1;
         PAT_ZEROS: pre_bit = 1'b0;
         PAT_LOHI:  pre_bit = odd;
         default:   pre_bit = ~odd;
      endcase
   endfunction

endpackage

// File: rtl/mtx_cfg_reg.sv
module mtx_cfg_reg
   import mtx_pkg::*;
#(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             wp,
   input  logic [CFG_W-1:0] wdata,
   output mtx_cfg_t         cfg,
   output logic [CFG_W-1:0] rdata
);

   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we && !wp) begin
         cfg.plen <= wdata[PLEN_LSB +: PLEN_W];
         cfg.pat  <= pat_e'(wdata[PAT_LSB +: 2]);
         cfg.pol  <= wdata[POL_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      rdata[PLEN_LSB +: PLEN_W] = cfg.plen;
      rdata[PAT_LSB +: 2]       = cfg.pat;
      rdata[POL_BIT]            = cfg.pol;
   end

endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
   import mtx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  mtx_cfg_t          cfg,
   output logic              s_ready,
   output logic              busy,
   output logic              phase,
   output logic              in_pre,
   output logic              idx_odd,
   output logic              data_lsb,
   output mtx_cfg_t          snap
);

   localparam int MAX_PL = (1 << PLEN_W) - 1;
   localparam int IDX_W  = $clog2(MAX_PL + DATA_W + 1);
   localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              busy_q;
   logic              phase_q;
   logic [IDX_W-1:0]  pl_ext;
   logic              last_bit;
   logic              accept;

   assign pl_ext   = IDX_W'(snap.plen);
   assign in_pre   = idx_q < pl_ext;
   assign last_bit = idx_q == (pl_ext + DATA_LAST);
   assign accept   = s_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         idx_q   <= '0;
         sh_q    <= '0;
         snap    <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         phase_q <= 1'b0;
         idx_q   <= '0;
         sh_q    <= s_data;
         snap    <= cfg;
      end else if (busy_q && half_tick) begin
         if (!phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            if (!in_pre) begin
               sh_q <= sh_q >> 1;
            end
            if (last_bit) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign s_ready  = !busy_q;
   assign busy     = busy_q;
   assign phase    = phase_q;
   assign idx_odd  = idx_q[0];
   assign data_lsb = sh_q[0];

endmodule

// File: rtl/mtx_symbol.sv
module mtx_symbol
   import mtx_pkg::*;
(
   input  logic in_pre,
   input  logic idx_odd,
   input  logic data_lsb,
   input  pat_e pat,
   output logic sym
);

   always_comb begin
      if (in_pre) begin
         sym = pre_bit(pat, idx_odd);
      end else begin
         sym = data_lsb;
      end
   end

endmodule

// File: rtl/mtx_coder.sv
module mtx_coder #(
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic busy,
   input  logic phase,
   input  logic sym,
   input  logic pol,
   output logic line
);

   logic first_half;

   assign first_half = sym ^ pol;

   generate
      if (IDLE_LVL) begin : g_idle_hi
         assign line = busy ? (phase ? ~first_half : first_half) : 1'b1;
      end else begin : g_idle_lo
         assign line = busy ? (phase ? ~first_half : first_half) : 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mtx_top.sv
module mtx_top
   import mtx_pkg::*;
#(
   parameter int CFG_W    = 16,
   parameter int DATA_W   = 8,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              wp_en,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_ready,
   output logic              line_out,
   output logic              busy
);

   generate
      if (CFG_W < CFG_MIN_W) begin : g_bad_cfg_w
         $error("CFG_W too small for the configuration fields");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be positive");
      end
   endgenerate

   mtx_cfg_t cfg_q;
   mtx_cfg_t snap;
   logic     phase;
   logic     in_pre;
   logic     idx_odd;
   logic     data_lsb;
   logic     sym;

   mtx_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wp    (wp_en),
      .wdata (cfg_wdata),
      .cfg   (cfg_q),
      .rdata (cfg_rdata)
   );

   mtx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .s_valid   (s_valid),
      .s_data    (s_data),
      .cfg       (cfg_q),
      .s_ready   (s_ready),
      .busy      (busy),
      .phase     (phase),
      .in_pre    (in_pre),
      .idx_odd   (idx_odd),
      .data_lsb  (data_lsb),
      .snap      (snap)
   );

   mtx_symbol u_sym (
      .in_pre   (in_pre),
      .idx_odd  (idx_odd),
      .data_lsb (data_lsb),
      .pat      (snap.pat),
      .sym      (sym)
   );

   mtx_coder #(.IDLE_LVL(IDLE_LVL)) u_coder (
      .busy  (busy),
      .phase (phase),
      .sym   (sym),
      .pol   (snap.pol),
      .line  (line_out)
   );

endmodule

// File: rtl/mtx_chk.sv
module mtx_chk #(
   parameter int CFG_W    = 16,
   parameter bit IDLE_LVL = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             half_tick,
   input logic             cfg_we,
   input logic             wp_en,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             s_valid,
   input logic             s_ready,
   input logic             line_out,
   input logic             busy
);

   // parity of half-bits completed in the current frame
   logic hpar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpar_q <= 1'b0;
      end else if (s_valid && s_ready) begin
         hpar_q <= 1'b0;
      end else if (busy && half_tick) begin
         hpar_q <= ~hpar_q;
      end
   end

   assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (line_out == IDLE_LVL));

   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> busy);

   assert_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !s_ready);

   assert_wp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && wp_en) |=> $stable(cfg_rdata));

   assert_line_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !half_tick) |=> $stable(line_out));

   assert_mid_bit_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && half_tick && !hpar_q) |=> (line_out != $past(line_out)));

endmodule

bind mtx_top mtx_chk #(.CFG_W(CFG_W), .IDLE_LVL(IDLE_LVL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .half_tick (half_tick),
   .cfg_we    (cfg_we),
   .wp_en     (wp_en),
   .cfg_rdata (cfg_rdata),
   .s_valid   (s_valid),
   .s_ready   (s_ready),
   .line_out  (line_out),
   .busy      (busy)
);

// File: tb/sim_mtx_top.sv
`timescale 1ns/1ps
module sim_mtx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        half_tick = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        wp_en = 1'b0;
   logic [15:0] cfg_rdata;
   logic        s_valid = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_ready;
   logic        line_out;
   logic        busy;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // shadow configuration, kept from the write rules alone
   logic [3:0] sh_pl  = '0;
   logic [1:0] sh_pat = '0;
   logic       sh_pol = 1'b0;

   always #10 clk = ~clk;

   mtx_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .wp_en     (wp_en),
      .cfg_rdata (cfg_rdata),
      .s_valid   (s_valid),
      .s_data    (s_data),
      .s_ready   (s_ready),
      .line_out  (line_out),
      .busy      (busy)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   function automatic logic exp_half(input logic [7:0] d, input logic [3:0] pl,
                                     input logic [1:0] pat, input logic pol, input int h);
      int  b;
      logic s;
      b = h / 2;
      if (b < int'(pl)) begin
         case (pat)
            2'd0: s = 1'b1;
            2'd1: s = 1'b0;
            2'd2: s = (b % 2) == 1;
            default: s = (b % 2) == 0;
         endcase
      end else begin
         s = d[b - int'(pl)];
      end
      s = s ^ pol;
      return (h % 2 == 1) ? ~s : s;
   endfunction

   task automatic cfg_write(input logic [15:0] w);
      cfg_wdata = w;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!wp_en) begin
         sh_pl  = w[3:0];
         sh_pat = w[9:8];
         sh_pol = w[12];
      end
   endtask

   // runs one frame; if mid is set, a new config is written during the frame (R10)
   task automatic run_frame(input logic [7:0] d, input bit mid, input logic [15:0] midw);
      logic [3:0] pl;
      logic [1:0] pat;
      logic       pol;
      int         nh;
      pl = sh_pl; pat = sh_pat; pol = sh_pol;
      nh = 2 * (int'(pl) + 8);
      s_data = d;
      s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      check("R9 busy after accept", busy, 1);
      check("R9 ready low while busy", s_ready, 0);
      for (int h = 0; h < nh; h++) begin
         if (h / 2 < int'(pl))
            check(pol ? "R7 preamble half" : "R5 preamble half", line_out,
                  exp_half(d, pl, pat, pol, h));
         else
            check(pol ? "R7 data half" : "R8 data half", line_out,
                  exp_half(d, pl, pat, pol, h));
         if (mid && h == 3) begin
            cfg_write(midw);
            check("R11 line held over write", line_out, exp_half(d, pl, pat, pol, h));
         end
         check("R9 busy within frame", busy, 1);
         half_tick = 1'b1;
         @(negedge clk);
         half_tick = 1'b0;
         if (h + 1 < nh) begin
            int gap;
            gap = int'($urandom_range(0, 2));
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               check("R11 line stable between ticks", line_out,
                     exp_half(d, pl, pat, pol, h + 1));
            end
         end
      end
      check("R9 busy drops at frame end", busy, 0);
      check("R1 idle high after frame", line_out, 1);
      check("R9 ready after frame", s_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 line idle", line_out, 1);
      check("R1 busy low", busy, 0);
      check("R1 ready high", s_ready, 1);
      check("R1 cfg reset", cfg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 line idle after release", line_out, 1);

      // R4 no preamble, R6 polarity 0, R8 bit order
      run_frame(8'h01, 1'b0, 16'h0);
      run_frame(8'h80, 1'b0, 16'h0);

      // R2 field placement and readback
      cfg_write(16'hFFFF);
      check("R2 readback fields", cfg_rdata, 32'h130F);
      cfg_write(16'h0205);
      check("R2 readback pattern 2 len 5", cfg_rdata, 32'h0205);

      // R3 write protect
      wp_en = 1'b1;
      cfg_write(16'h1301);
      check("R3 readback unchanged", cfg_rdata, 32'h0205);
      run_frame(8'hA5, 1'b0, 16'h0);
      wp_en = 1'b0;

      // R5/R7 every pattern with both polarities, R4 length 1 and 15
      for (int p = 0; p < 4; p++) begin
         for (int q = 0; q < 2; q++) begin
            cfg_write({3'b0, q[0], 2'b0, p[1:0], 4'b0, 4'd3});
            run_frame(8'h00, 1'b0, 16'h0);
            run_frame(8'hFF, 1'b0, 16'h0);
         end
      end
      cfg_write(16'h0201);
      run_frame(8'h5A, 1'b0, 16'h0);
      cfg_write(16'h130F);
      run_frame(8'h3C, 1'b0, 16'h0);

      // R10 configuration frozen during a frame
      cfg_write(16'h0204);
      run_frame(8'hC3, 1'b1, 16'h1108);
      check("R10 new config stored", cfg_rdata, 32'h1108);
      run_frame(8'hC3, 1'b0, 16'h0);

      // random frames
      for (int k = 0; k < 30; k++) begin
         logic [15:0] w;
         w = '0;
         w[3:0]  = 4'($urandom_range(0, 15));
         w[9:8]  = 2'($urandom_range(0, 3));
         w[12]   = 1'($urandom_range(0, 1));
         cfg_write(w);
         run_frame(8'($urandom_range(0, 255)), 1'b0, 16'h0);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule